// File: doc/BRIEF.md
# Gain-Adaptive Correlated Double Sampling Column Counter

This block is the digital half of one column of a single-slope converter. It does correlated double sampling in the count itself. First the reference level is counted while the comparator output stays high. That code is then negated, and the signal level is counted upward on top of it. The register left at the end holds the signal count minus the reference count, as a signed number.

The column clock counts on both of its edges. Here that is modelled by a `tick` input, which pulses once per half period, so each tick is one count. The least significant cell only keeps the parity of the count. That cell is written when the comparator falls, or when a phase starts, and not on every tick; a separate clock-phase tracker toggles with the ticks.

For medium or low gain, the signal phase counts in steps of 2 or 4 LSB. The parity cell is rerouted to a higher cell, and the cells below it are bypassed. Before counting starts, the reference bit that the parity cell displaces is preloaded into it, and the old parity is parked in a latch. The finished result leaves through a valid/ready output.

Top module: `cds_gain_counter`

## Requirements
- R1: After reset `res_valid` is 0 and `res_data` is 0.
- R2: A pulse on `ref_go` clears the count and starts the reference phase. Each cycle with `tick`=1 and `cmp`=1 adds one count. If the signal phase then counts nothing, the result is minus the reference count.
- R3: With gain code 2'b00 (step 1), the result is Nsig − Nref. Nref is the number of reference ticks and Nsig the number of signal ticks.
- R4: With gain code 2'b01 (step 2), the result is 2·Nsig − Nref, for every parity of Nref.
- R5: With gain code 2'b10, and also 2'b11 (step 4), the result is 4·Nsig − Nref.
- R6: Cycles with `tick`=0 add nothing, so gaps between ticks leave the result unchanged.
- R7: Once `cmp` is sampled low, the phase ends. A later rise of `cmp` with ticks, before the next phase start, changes nothing.
- R8: The reference count stops at full scale 2^(W−1)−1 and does not wrap.
- R9: If the signal count would pass full scale 2^(W−1)−1, the result is exactly 2^(W−1)−1.
- R10: `cmp` sampled low during the signal phase ends the conversion. `res_valid` rises at that same clock edge. `res_data` then holds steady until a cycle with `res_ready`=1, after which `res_valid` falls.
- R11: While a result is waiting (`res_valid`=1, `res_ready`=0), `ref_go` and `sig_go` are ignored. The stored count is not cleared, and no phase starts.
- R12: The reference code is negated only in a cycle with both `hold`=1 and `inv`=1. `inv` alone leaves it positive, so the result becomes Nref + step·Nsig.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| tick | input | 1 | One pulse per half period of the column clock |
| cmp | input | 1 | Comparator output; counting runs while it is high |
| ref_go | input | 1 | Clears the count and starts the reference (down) phase |
| sig_go | input | 1 | Starts the signal (up) phase using `gain` |
| gain | input | 2 | Step select: 00 step 1, 01 step 2, 10 or 11 step 4 |
| hold | input | 1 | Freezes the count for inversion |
| inv | input | 1 | Negates the stored reference code when `hold` is also high |
| res_ready | input | 1 | Sink accepts the result |
| res_valid | output | 1 | Result available |
| res_data | output | W | Signed result, signal minus reference |

## Verification
Most internal faults stay hidden until a conversion ends. A wrong parity or latch bit, a wrong preload, or a missing carry into the inversion makes `res_data` off by one LSB or one step, on the first conversion whose reference parity or gain exercises that path. A broken carry chain or bypass shows only when the count crosses the affected bit. So the sweep covers every reference count up to past full scale, for every gain and many signal counts. A fault in the clamp or the handshake shows on the cycle the result is presented, or while it waits.

// File: rtl/cds_gain_pkg.sv
package cds_gain_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REF  = 2'd1,
    PH_SIG  = 2'd2
  } phase_e;

  // step = 1 << shift; code 11 behaves as the coarsest step
  function automatic logic [1:0] step_shift(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/cds_parity_cell.sv
// Least significant cell: a clock-phase tracker that follows the ticks, a
// parity flop written only at comparator fall or phase start, and a latch
// that keeps the reference parity while the cell stands in for a higher bit.
module cds_parity_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic preload,
  input  logic preload_bit,
  input  logic advance,
  input  logic capture,
  output logic par_q,
  output logic phase_q,
  output logic keep_q,
  output logic carry
);

  logic flip;

  // parity toggles at capture only if the tracked phase differs from it
  assign flip  = par_q ^ phase_q;
  assign carry = advance & phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      phase_q <= 1'b0;
      keep_q  <= 1'b0;
    end else if (clear) begin
      par_q   <= 1'b0;
      phase_q <= 1'b0;
      keep_q  <= 1'b0;
    end else if (preload) begin
      keep_q  <= par_q;
      par_q   <= preload_bit;
      phase_q <= preload_bit;
    end else begin
      if (advance) phase_q <= ~phase_q;
      if (capture && flip) par_q <= ~par_q;
    end
  end

endmodule

// File: rtl/cds_upper_cells.sv
// Cells 1..W-1. The carry enters at cell shift+1; cells at or below shift
// are bypassed and keep their value. Negation loads ~q plus the carry that
// the parity cell asks for.
module cds_upper_cells #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         negate,
  input  logic         neg_carry,
  input  logic         carry_in,
  input  logic [1:0]   shift,
  output logic [W-1:1] q
);

  localparam int NC = W - 1;

  logic [W-1:1] c;
  logic [W-1:1] neg_val;
  int           sh;

  assign sh      = int'(shift);
  assign neg_val = ~q + {{(NC-1){1'b0}}, neg_carry};

  always_comb begin
    c[1] = (sh == 0) ? carry_in : 1'b0;
    for (int i = 2; i < W; i++) begin
      if (i == sh + 1)     c[i] = carry_in;
      else if (i > sh + 1) c[i] = c[i-1] & q[i-1];
      else                 c[i] = 1'b0;
    end
  end

  for (genvar i = 1; i < W; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (clear)  q[i] <= 1'b0;
      else if (negate) q[i] <= neg_val[i];
      else if (c[i])   q[i] <= ~q[i];
    end
  end

endmodule

// File: rtl/cds_result_reg.sv
// Output stage: loads at the end of the signal phase, holds until accepted.
module cds_result_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cds_gain_counter.sv
module cds_gain_counter
  import cds_gain_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cmp,
  input  logic         ref_go,
  input  logic         sig_go,
  input  logic [1:0]   gain,
  input  logic         hold,
  input  logic         inv,
  input  logic         res_ready,
  output logic         res_valid,
  output logic [W-1:0] res_data
);

  localparam int                MAXV  = 2**(W-1) - 1;
  localparam logic [W-1:0]      MAX_W = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W:0] MAX_X = {2'b00, {(W-1){1'b1}}};

  phase_e       ph;
  logic [1:0]   sh;
  logic [1:0]   sh_new;
  logic         sat;
  logic         running;
  logic         pend;
  logic         ref_start;
  logic         sig_start;
  logic         inv_do;
  logic         stop;
  logic         load;
  logic         advance;
  logic         blocked;
  logic         carry;
  logic         par_q;
  logic         phase_q;
  logic         keep_q;
  logic         pre_bit;
  logic [W-1:1] upq;
  logic [W-1:0] live;
  logic [2:0]   step3;
  logic signed [W:0] live_x;
  logic signed [W:0] lim_x;

  assign running   = (ph != PH_IDLE);
  assign pend      = res_valid & ~res_ready;
  assign ref_start = ref_go & ~running & ~pend;
  assign sig_start = sig_go & ~ref_go & ~running & ~pend;
  assign inv_do    = hold & inv & ~running & ~ref_go & ~sig_go;
  assign stop      = running & ~cmp;
  assign load      = stop & (ph == PH_SIG);
  assign sh_new    = step_shift(gain);

  // value as seen through the current routing of the parity cell
  always_comb begin
    case (sh)
      2'd0:    live = {upq, phase_q};
      2'd1:    live = {upq[W-1:2], phase_q, keep_q};
      default: live = {upq[W-1:3], phase_q, upq[1], keep_q};
    endcase
  end

  always_comb begin
    case (sh_new)
      2'd0:    pre_bit = par_q;
      2'd1:    pre_bit = upq[1];
      default: pre_bit = upq[2];
    endcase
  end

  assign step3   = 3'd1 << sh;
  assign live_x  = $signed({live[W-1], live});
  assign lim_x   = MAX_X - $signed({{(W-2){1'b0}}, step3});
  assign blocked = live_x > lim_x;
  assign advance = running & cmp & tick & ~blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      sh  <= 2'd0;
      sat <= 1'b0;
    end else begin
      if (ref_start) begin
        ph  <= PH_REF;
        sh  <= 2'd0;
        sat <= 1'b0;
      end else if (sig_start) begin
        ph  <= PH_SIG;
        sh  <= sh_new;
        sat <= 1'b0;
      end else if (stop) begin
        ph  <= PH_IDLE;
      end else if ((ph == PH_SIG) && cmp && tick && blocked) begin
        sat <= 1'b1;
      end
    end
  end

  cds_parity_cell u_lsb (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (ref_start),
    .preload     (sig_start),
    .preload_bit (pre_bit),
    .advance     (advance),
    .capture     (stop),
    .par_q       (par_q),
    .phase_q     (phase_q),
    .keep_q      (keep_q),
    .carry       (carry)
  );

  cds_upper_cells #(.W(W)) u_upper (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ref_start),
    .negate    (inv_do),
    .neg_carry (~par_q),
    .carry_in  (carry),
    .shift     (sh),
    .q         (upq)
  );

  cds_result_reg #(.W(W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (sat ? MAX_W : live),
    .ready (res_ready),
    .valid (res_valid),
    .dout  (res_data)
  );

  initial begin
    if (W < 4 || MAXV < 4) $error("cds_gain_counter needs W >= 4");
  end

endmodule

// File: rtl/cds_gain_counter_chk.sv
module cds_gain_counter_chk #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmp,
  input logic         hold,
  input logic         inv,
  input logic         ref_go,
  input logic         res_ready,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         running,
  input logic         par_q,
  input logic [W-1:1] upq,
  input logic         stop,
  input logic         ref_start,
  input logic         sig_start
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(running && !cmp));

  assert_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_q) |-> $past(stop || ref_start || sig_start));

  assert_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> !running);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ref_go && !(hold && inv)) |=> $stable(upq));

endmodule

bind cds_gain_counter cds_gain_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp       (cmp),
  .hold      (hold),
  .inv       (inv),
  .ref_go    (ref_go),
  .res_ready (res_ready),
  .res_valid (res_valid),
  .res_data  (res_data),
  .running   (running),
  .par_q     (par_q),
  .upq       (upq),
  .stop      (stop),
  .ref_start (ref_start),
  .sig_start (sig_start)
);

// File: tb/sim_cds_gain_counter.sv
module sim_cds_gain_counter;

  localparam int W    = 6;
  localparam int MAXV = 2**(W-1) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         cmp = 1'b0;
  logic         ref_go = 1'b0;
  logic         sig_go = 1'b0;
  logic [1:0]   gain = 2'b00;
  logic         hold = 1'b0;
  logic         inv = 1'b0;
  logic         res_ready = 1'b0;
  logic         res_valid;
  logic [W-1:0] res_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cds_gain_counter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp(cmp), .ref_go(ref_go),
    .sig_go(sig_go), .gain(gain), .hold(hold), .inv(inv),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sval();
    return int'($signed(res_data));
  endfunction

  task automatic count_ticks(input int n, input bit gap);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      if (gap) begin
        tick = 1'b0;
        @(negedge clk);
      end
    end
    tick = 1'b0;
  endtask

  // one full conversion; checks the result when it appears
  task automatic conv(input int nr, input int ns, input int code,
                      input bit do_inv, input bit gap, input bit retog,
                      input bit keep, input string req);
    int step, nre, base, d, exp;
    step = (code == 0) ? 1 : (code == 1) ? 2 : 4;
    nre  = (nr > MAXV) ? MAXV : nr;
    base = do_inv ? -nre : nre;
    d    = base + step * ns;
    exp  = (d > MAXV) ? MAXV : d;
    @(negedge clk);
    cmp = 1'b1; ref_go = 1'b1;
    @(negedge clk);
    ref_go = 1'b0;
    count_ticks(nr, gap);
    cmp = 1'b0;
    @(negedge clk);
    if (retog) begin
      cmp = 1'b1; tick = 1'b1;
      repeat (4) @(negedge clk);
      cmp = 1'b0; tick = 1'b0;
      @(negedge clk);
    end
    if (do_inv) hold = 1'b1;
    inv = 1'b1;
    @(negedge clk);
    hold = 1'b0; inv = 1'b0;
    gain = 2'(code); sig_go = 1'b1; cmp = 1'b1;
    @(negedge clk);
    sig_go = 1'b0;
    count_ticks(ns, gap);
    cmp = 1'b0;
    @(negedge clk);
    chk({req, " valid at end"}, int'(res_valid), 1);
    chk(req, sval(), exp);
    if (!keep) begin
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
    end
  endtask

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 data", sval(), 0);

    // near-exhaustive sweep
    for (int g = 0; g < 3; g++) begin
      for (int nr = 0; nr <= MAXV + 2; nr++) begin
        for (int ns = 0; ns <= 12; ns++) begin
          string r;
          int st;
          st = (g == 0) ? 1 : (g == 1) ? 2 : 4;
          if (st * ns - ((nr > MAXV) ? MAXV : nr) > MAXV) r = "R9";
          else if (nr > MAXV) r = "R8";
          else if (ns == 0) r = "R2";
          else if (g == 0) r = "R3";
          else if (g == 1) r = "R4";
          else r = "R5";
          conv(nr, ns, g, 1'b1, 1'b0, 1'b0, 1'b0, r);
        end
      end
    end

    // code 11 acts as step 4
    conv(9, 5, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R5 code11");
    conv(4, 2, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R5 code11");
    // gaps between ticks
    conv(7, 5, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    conv(11, 6, 1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    conv(5, 7, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    // comparator rises again after the reference phase ended
    conv(6, 4, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    conv(13, 3, 1, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    // inv without hold: no negation
    conv(3, 4, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
    conv(5, 3, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
    conv(6, 5, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R12");

    // result waits: held, and phase starts ignored
    conv(5, 2, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
    prev = sval();
    repeat (3) @(negedge clk);
    chk("R10 still valid", int'(res_valid), 1);
    chk("R10 stable", sval(), prev);
    cmp = 1'b1; ref_go = 1'b1;
    @(negedge clk);
    ref_go = 1'b0;
    count_ticks(5, 1'b0);
    cmp = 1'b0;
    @(negedge clk);
    chk("R11 valid kept", int'(res_valid), 1);
    chk("R11 data kept", sval(), prev);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R10 drop after ready", int'(res_valid), 0);
    // signal phase on the untouched count: prev + 3
    gain = 2'b00; sig_go = 1'b1; cmp = 1'b1;
    @(negedge clk);
    sig_go = 1'b0;
    count_ticks(3, 1'b0);
    cmp = 1'b0;
    @(negedge clk);
    chk("R11 count not cleared", sval(), prev + 3);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule